// File: doc/BRIEF.md
# UART FIFO Interrupt and DMA-Ready Generator

This block watches the fill levels of a UART's receive and transmit FIFOs (128 entries each by default). From them it derives one active-high interrupt line and two active-low DMA request lines. The receive side raises the interrupt when the receive FIFO reaches its programmable trigger level. It also raises it when a receive-timeout pulse arrives while data is waiting. The transmit side raises the interrupt when the transmit FIFO holds fewer entries than its own trigger level. A host status read acknowledges that interrupt, and so does refilling the FIFO to the trigger.

The logic is four small state machines. Receive interrupt states: `RX_QUIET`, `RX_ABOVE` (count at or above trigger) and `RX_TIMEOUT` (timeout pending below trigger). Transmit interrupt states: `TX_OFF` (enable clear), `TX_ARMED` (enabled, count at or above trigger), `TX_PEND` (interrupt raised) and `TX_ACKED` (acknowledged by a status read, waiting for a refill).

Two instances of one ready machine, with states `DR_IDLE` and `DR_ASSERT`, produce the DMA lines. The receive instance runs in follow mode, asserting while the FIFO holds data. The transmit instance runs in sticky mode. It asserts once the FIFO is empty and the final byte has left the shift register, and releases on the next load.

The named transitions are as follows.
- Receive: `QUIET/ABOVE/TIMEOUT -> ABOVE` when at level, `-> TIMEOUT` on a timeout with data, `TIMEOUT -> QUIET` on a read or when empty.
- Transmit: `any -> OFF` when the enable drops, `OFF/ARMED -> PEND` when below trigger, `OFF -> ARMED` when at or above trigger, `PEND -> ACKED` on a status read while still below, `PEND/ACKED -> ARMED` on a refill.
- Ready: `DR_IDLE -> DR_ASSERT` on the enter condition, `DR_ASSERT -> DR_IDLE` on the leave condition.

Every output is registered. An input change sampled at a clock edge is visible on the outputs right after that same edge.

Top module: `uart_irq_ready_gen`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `irq` is 0 and `rxrdy_n` and `txrdy_n` are 1, whatever the other inputs are.
- R2: When `rx_count` is nonzero and `rx_count >= rx_trig` at an edge, `irq` is 1 after that edge.
- R3: With no timeout pending and `tx_ien` low, `irq` returns to 0 at the first edge where `rx_count < rx_trig`.
- R4: A `rx_timeout` pulse at an edge where `rx_count` is nonzero raises `irq` after that edge. A pulse while `rx_count` is 0 is ignored and `irq` stays 0.
- R5: A pending receive timeout holds `irq` high until the first edge with `rx_read` high, or the first edge with `rx_count` equal to 0, whichever comes first.
- R6: `rxrdy_n` is 0 after every edge at which `rx_count` is nonzero, and 1 after every edge at which it is 0.
- R7: While `tx_ien` is 0 the transmit side contributes nothing to `irq`. Clearing `tx_ien` removes a pending transmit interrupt at the next edge.
- R8: While `tx_ien` is 1, `tx_count < tx_trig` raises `irq` at the next edge. This includes the count reaching 0, and setting `tx_ien` while the count is already below the trigger.
- R9: `isr_read` high at an edge clears a pending transmit interrupt. The interrupt stays clear while the count remains below the trigger, until the count first reaches `tx_trig` and then drops below it again.
- R10: `tx_count >= tx_trig` clears a pending transmit interrupt at the next edge. When `isr_read` arrives at that same edge, `irq` is still 0 after it.
- R11: `txrdy_n` goes to 0 after an edge where `tx_count` is 0 and `tx_shift_done` is 1. It then stays 0 until an edge with `tx_count` nonzero, after which it is 1. An empty FIFO without `tx_shift_done` does not lower it.
- R12: `irq` is active high and equals the OR of the receive and transmit conditions. Clearing one source leaves `irq` at 1 while the other remains active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_count | input | CNT_W (8) | Receive FIFO fill count, 0..DEPTH |
| rx_trig | input | CNT_W (8) | Receive trigger level |
| rx_timeout | input | 1 | Single-cycle receive data timeout pulse |
| rx_read | input | 1 | Host read of the receive FIFO |
| tx_count | input | CNT_W (8) | Transmit FIFO fill count, 0..DEPTH |
| tx_trig | input | CNT_W (8) | Transmit trigger level |
| tx_ien | input | 1 | Transmit interrupt enable |
| isr_read | input | 1 | Interrupt status read strobe |
| tx_shift_done | input | 1 | Last byte has left the transmit shift register |
| irq | output | 1 | Interrupt, active high |
| rxrdy_n | output | 1 | Receive DMA ready, active low |
| txrdy_n | output | 1 | Transmit DMA ready, active low |

## Verification
Wrong state inside any of the four machines reaches a port on the very next edge, because every output is the registered decode of the next state. A transmit machine stuck in `TX_ACKED` shows up as `irq` staying low after a refill followed by a drain. One that skips `TX_ACKED` shows up as `irq` coming back one cycle after a status read. A lost receive timeout flag shows up as `irq` dropping before any read. A ready machine that forgets its sticky state shows up as `txrdy_n` rising while the FIFO is still empty. The bench compares all three outputs every cycle against a model, so any such divergence is reported in the cycle it happens.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [1:0] {
        RX_QUIET   = 2'd0,
        RX_ABOVE   = 2'd1,
        RX_TIMEOUT = 2'd2
    } rx_st_e;

    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_ARMED = 2'd1,
        TX_PEND  = 2'd2,
        TX_ACKED = 2'd3
    } tx_st_e;

    typedef enum logic {
        DR_IDLE   = 1'b0,
        DR_ASSERT = 1'b1
    } dr_st_e;

endpackage

// File: rtl/uirq_rx_fsm.sv
module uirq_rx_fsm
    import uirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    input  logic             timeout,
    input  logic             rd,
    output logic             irq_d
);

    rx_st_e st_q, st_nxt;
    logic   nonempty, at_level, tmo_take;

    always_ff @(posedge clk) begin
        if (rst) st_q <= RX_QUIET;
        else     st_q <= st_nxt;
    end

    always_comb begin
        nonempty = (count != '0);
        at_level = nonempty && (count >= trig);
        tmo_take = timeout && nonempty;
        st_nxt   = RX_QUIET;
        unique case (st_q)
            RX_QUIET, RX_ABOVE: begin
                if (at_level)      st_nxt = RX_ABOVE;
                else if (tmo_take) st_nxt = RX_TIMEOUT;
                else               st_nxt = RX_QUIET;
            end
            RX_TIMEOUT: begin
                if (at_level)                        st_nxt = RX_ABOVE;
                else if (tmo_take || (!rd && nonempty)) st_nxt = RX_TIMEOUT;
                else                                 st_nxt = RX_QUIET;
            end
            default: st_nxt = RX_QUIET;
        endcase
    end

    always_comb begin
        irq_d = (st_nxt == RX_ABOVE) || (st_nxt == RX_TIMEOUT);
    end

endmodule

// File: rtl/uirq_tx_fsm.sv
module uirq_tx_fsm
    import uirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    input  logic             ien,
    input  logic             ack,
    output logic             irq_d
);

    tx_st_e st_q, st_nxt;
    logic   below;

    always_ff @(posedge clk) begin
        if (rst) st_q <= TX_OFF;
        else     st_q <= st_nxt;
    end

    always_comb begin
        below  = (count < trig);
        st_nxt = st_q;
        if (!ien) begin
            st_nxt = TX_OFF;
        end else begin
            unique case (st_q)
                TX_OFF, TX_ARMED: begin
                    st_nxt = below ? TX_PEND : TX_ARMED;
                end
                TX_PEND: begin
                    if (!below)   st_nxt = TX_ARMED;
                    else if (ack) st_nxt = TX_ACKED;
                    else          st_nxt = TX_PEND;
                end
                TX_ACKED: begin
                    st_nxt = below ? TX_ACKED : TX_ARMED;
                end
                default: st_nxt = TX_OFF;
            endcase
        end
    end

    always_comb begin
        irq_d = (st_nxt == TX_PEND);
    end

endmodule

// File: rtl/uirq_ready_fsm.sv
module uirq_ready_fsm
    import uirq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter bit STICKY = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic             arm,
    output logic             req_d
);

    localparam bit ENTER_ON_EMPTY = STICKY;

    dr_st_e st_q, st_nxt;
    logic   empty, enter, leave;

    always_ff @(posedge clk) begin
        if (rst) st_q <= DR_IDLE;
        else     st_q <= st_nxt;
    end

    generate
        if (ENTER_ON_EMPTY) begin : g_sticky
            always_comb begin
                enter = (count == '0) && arm;
                leave = (count != '0);
            end
        end else begin : g_follow
            always_comb begin
                enter = (count != '0) && arm;
                leave = (count == '0);
            end
        end
    endgenerate

    always_comb begin
        empty  = (count == '0);
        st_nxt = st_q;
        unique case (st_q)
            DR_IDLE:   st_nxt = enter ? DR_ASSERT : DR_IDLE;
            DR_ASSERT: st_nxt = leave ? DR_IDLE : DR_ASSERT;
            default:   st_nxt = DR_IDLE;
        endcase
    end

    always_comb begin
        req_d = (st_nxt == DR_ASSERT) && (ENTER_ON_EMPTY ? empty : !empty);
    end

endmodule

// File: rtl/uart_irq_ready_gen.sv
module uart_irq_ready_gen
    import uirq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             rx_read,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_trig,
    input  logic             tx_ien,
    input  logic             isr_read,
    input  logic             tx_shift_done,
    output logic             irq,
    output logic             rxrdy_n,
    output logic             txrdy_n
);

    logic rx_irq_d, tx_irq_d, rx_req_d, tx_req_d;

    uirq_rx_fsm #(.CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .count   (rx_count),
        .trig    (rx_trig),
        .timeout (rx_timeout),
        .rd      (rx_read),
        .irq_d   (rx_irq_d)
    );

    uirq_tx_fsm #(.CNT_W(CNT_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .count (tx_count),
        .trig  (tx_trig),
        .ien   (tx_ien),
        .ack   (isr_read),
        .irq_d (tx_irq_d)
    );

    uirq_ready_fsm #(.CNT_W(CNT_W), .STICKY(1'b0)) u_rx_rdy (
        .clk   (clk),
        .rst   (rst),
        .count (rx_count),
        .arm   (1'b1),
        .req_d (rx_req_d)
    );

    uirq_ready_fsm #(.CNT_W(CNT_W), .STICKY(1'b1)) u_tx_rdy (
        .clk   (clk),
        .rst   (rst),
        .count (tx_count),
        .arm   (tx_shift_done),
        .req_d (tx_req_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            rxrdy_n <= 1'b1;
            txrdy_n <= 1'b1;
        end else begin
            irq     <= rx_irq_d | tx_irq_d;
            rxrdy_n <= !rx_req_d;
            txrdy_n <= !tx_req_d;
        end
    end

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] rx_trig,
    input logic             rx_timeout,
    input logic             rx_read,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] tx_trig,
    input logic             tx_ien,
    input logic             isr_read,
    input logic             tx_shift_done,
    input logic             irq,
    input logic             rxrdy_n,
    input logic             txrdy_n
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!irq && rxrdy_n && txrdy_n));

    // R2
    rx_level_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count != '0 && rx_count >= rx_trig) |=> irq);

    // R6
    rxrdy_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count != '0) |=> !rxrdy_n);

    // R6
    rxrdy_high_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |=> rxrdy_n);

    // R7
    tx_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_ien && rx_count == '0) |=> !irq);

    // R10
    tx_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count >= tx_trig && rx_count == '0) |=> !irq);

    // R11
    txrdy_load_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count != '0) |=> txrdy_n);

    // R11
    txrdy_done_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count == '0 && tx_shift_done) |=> !txrdy_n);

    // R4
    rx_tmo_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0 && rx_timeout && (!tx_ien || tx_count >= tx_trig)) |=> !irq);

endmodule

bind uart_irq_ready_gen uirq_chk #(.CNT_W(CNT_W)) u_uirq_chk (.*);

// File: tb/test_uart_irq_ready_gen.sv
module test_uart_irq_ready_gen;

    localparam int DEPTH = 128;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] rx_count, rx_trig, tx_count, tx_trig;
    logic             rx_timeout, rx_read, tx_ien, isr_read, tx_shift_done;
    logic             irq, rxrdy_n, txrdy_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model state
    bit m_tmo, m_txp, m_txack, m_txr;
    bit e_irq, e_rxrdy_n, e_txrdy_n;

    always #2 clk = ~clk;

    uart_irq_ready_gen #(.DEPTH(DEPTH)) i_uart_irq_ready_gen (
        .clk(clk), .rst(rst),
        .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout), .rx_read(rx_read),
        .tx_count(tx_count), .tx_trig(tx_trig), .tx_ien(tx_ien), .isr_read(isr_read),
        .tx_shift_done(tx_shift_done),
        .irq(irq), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    function automatic bit rx_lvl(input int c, input int t);
        return (c != 0) && (c >= t);
    endfunction

    task automatic model_edge();
        bit lvl, tmo_n, below;
        if (rst) begin
            m_tmo = 0; m_txp = 0; m_txack = 0; m_txr = 0;
            e_irq = 0; e_rxrdy_n = 1; e_txrdy_n = 1;
            return;
        end
        lvl   = rx_lvl(rx_count, rx_trig);
        tmo_n = !lvl && (rx_count != 0) && (rx_timeout || (m_tmo && !rx_read));
        m_tmo = tmo_n;
        if (!tx_ien) begin
            m_txp = 0; m_txack = 0;
        end else begin
            below = tx_count < tx_trig;
            if (!below) begin
                m_txp = 0; m_txack = 0;
            end else if (m_txp && isr_read) begin
                m_txp = 0; m_txack = 1;
            end else if (!m_txack) begin
                m_txp = 1;
            end
        end
        if (tx_count != 0)          m_txr = 0;
        else if (tx_shift_done)     m_txr = 1;
        e_irq     = lvl || m_tmo || m_txp;
        e_rxrdy_n = (rx_count == 0);
        e_txrdy_n = !m_txr;
    endtask

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // one clock: inputs already set at negedge; model updates at edge; sample at next negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
    endtask

    task automatic clr_strobes();
        rx_timeout = 0; rx_read = 0; isr_read = 0; tx_shift_done = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; clr_strobes();
        rx_count = 5; rx_trig = 1; tx_count = 0; tx_trig = 8; tx_ien = 1;
        tx_shift_done = 1; rx_timeout = 1;
        @(negedge clk);
        step(); step();
        // R1
        chk(irq, 1'b0, "R1", "irq in reset");
        chk(rxrdy_n, 1'b1, "R1", "rxrdy_n in reset");
        chk(txrdy_n, 1'b1, "R1", "txrdy_n in reset");

        rst = 0; clr_strobes();
        rx_count = 0; rx_trig = 4; tx_count = 20; tx_trig = 8; tx_ien = 0;
        step();
        // R2 / R3
        rx_count = 3; step(); chk(irq, 1'b0, "R2", "below trigger");
        rx_count = 4; step(); chk(irq, 1'b1, "R2", "at trigger");
        rx_count = 7; step(); chk(irq, 1'b1, "R2", "above trigger");
        rx_count = 3; rx_read = 1; step(); chk(irq, 1'b0, "R3", "drop below trigger");
        clr_strobes();
        // R4
        rx_count = 0; step();
        rx_timeout = 1; step(); chk(irq, 1'b0, "R4", "timeout while empty");
        rx_count = 2; step(); chk(irq, 1'b1, "R4", "timeout with data");
        clr_strobes(); step(); chk(irq, 1'b1, "R5", "timeout held");
        rx_count = 3; step(); chk(irq, 1'b1, "R5", "held without read");
        rx_read = 1; rx_count = 2; step(); chk(irq, 1'b0, "R5", "cleared by read");
        clr_strobes(); rx_timeout = 1; step(); clr_strobes();
        rx_count = 0; step(); chk(irq, 1'b0, "R5", "cleared when empty");
        // R6
        chk(rxrdy_n, 1'b1, "R6", "empty rx");
        rx_count = 1; step(); chk(rxrdy_n, 1'b0, "R6", "first byte");
        rx_count = 0; step(); chk(rxrdy_n, 1'b1, "R6", "emptied");

        // transmit side
        tx_trig = 8; tx_count = 3; tx_ien = 0; step();
        chk(irq, 1'b0, "R7", "disabled below trigger");
        tx_ien = 1; step(); chk(irq, 1'b1, "R8", "enable while below");
        isr_read = 1; step(); chk(irq, 1'b0, "R9", "status read clears");
        clr_strobes(); tx_count = 2; step(); chk(irq, 1'b0, "R9", "stays clear below");
        tx_count = 8; step(); chk(irq, 1'b0, "R10", "refill");
        tx_count = 7; step(); chk(irq, 1'b1, "R8", "drop below again");
        tx_count = 8; isr_read = 1; step(); chk(irq, 1'b0, "R10", "read and refill together");
        clr_strobes(); tx_count = 9; step();
        tx_count = 0; step(); chk(irq, 1'b1, "R8", "direct to empty");
        tx_ien = 0; step(); chk(irq, 1'b0, "R7", "disable clears");
        // R11
        chk(txrdy_n, 1'b1, "R11", "empty without done");
        tx_shift_done = 1; step(); chk(txrdy_n, 1'b0, "R11", "last byte sent");
        clr_strobes(); step(); chk(txrdy_n, 1'b0, "R11", "sticky low");
        tx_count = 1; step(); chk(txrdy_n, 1'b1, "R11", "loaded");
        tx_count = 0; step(); chk(txrdy_n, 1'b1, "R11", "empty again no done");
        // R12
        rx_count = 5; rx_trig = 4; tx_ien = 1; tx_count = 2; step();
        chk(irq, 1'b1, "R12", "both sources");
        isr_read = 1; step(); chk(irq, 1'b1, "R12", "tx acked, rx still active");
        clr_strobes(); rx_read = 1; rx_count = 3; step();
        chk(irq, 1'b0, "R12", "both cleared");
        clr_strobes();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int d;
            if ($urandom_range(0, 99) == 0) rst = 1; else rst = 0;
            if ($urandom_range(0, 49) == 0) rx_trig = CNT_W'($urandom_range(1, 16));
            if ($urandom_range(0, 49) == 0) tx_trig = CNT_W'($urandom_range(1, 16));
            if ($urandom_range(0, 29) == 0) tx_ien = ~tx_ien;
            d = int'(rx_count) + $urandom_range(0, 4) - 2;
            if (d < 0) d = 0;
            if (d > 20) d = 20;
            rx_count = CNT_W'(d);
            if ($urandom_range(0, 7) == 0) tx_count = 0;
            else begin
                d = int'(tx_count) + $urandom_range(0, 4) - 2;
                if (d < 0) d = 0;
                if (d > 20) d = 20;
                tx_count = CNT_W'(d);
            end
            rx_timeout    = ($urandom_range(0, 9) == 0);
            rx_read       = ($urandom_range(0, 3) == 0);
            isr_read      = ($urandom_range(0, 5) == 0);
            tx_shift_done = ($urandom_range(0, 5) == 0);
            step();
            chk(irq, e_irq, "R12", "random irq");
            chk(rxrdy_n, e_rxrdy_n, "R6", "random rxrdy_n");
            chk(txrdy_n, e_txrdy_n, "R11", "random txrdy_n");
        end
        finish_run();
    end

endmodule